// File: doc/BRIEF.md
# Multiphase Synchronous Pulse-Burst Generator

This block produces short bursts of square-wave cycles for an impulse-radio transmitter. The burst frequency can reach twice the system clock. The block receives four clocks: a base clock and copies of it that lag by a quarter, a half and three quarters of a period. A rising edge on the burst trigger starts an on/off-keyed modulator in the base-clock domain. The modulator inverts its line on every base-clock edge for a programmed number of periods, then holds the line low.

Three delay registers copy the modulator line. Each one runs on one of the lagging clocks, so the copies trail the modulator by exact quarter-period steps, and this does not change with temperature. An XOR combiner turns the modulator line and the selected copies into the output. It merges either the modulator line with the quarter-lag copy, which gives a burst at the clock rate, or all four lines, which gives a burst at twice the clock rate.

Top module: `upg_pulse_gen`

## Requirements
- R1: While `rst` is high, `pulseOut` is low. After reset the modulator and the three delay registers hold zero.
- R2: `burstTrigger` is sampled on `clk0`. A low-to-high change seen in base period k drives the modulator high from the `clk0` edge that starts period k+2.
- R3: A burst holds the modulator level for exactly one base period at a time. The level alternates 1, 0, 1, … for `pulseWidth` periods, then stays 0 until the next trigger edge.
- R4: A trigger held high starts only one burst.
- R5: A trigger edge during a burst reloads the count with `pulseWidth` and sets the modulator high again.
- R6: A trigger edge while `pulseWidth` is 0 leaves the modulator at 0, and the output stays low.
- R7: The three delay copies equal the modulator level from a quarter, a half and three quarters of a base period earlier.
- R8: With `modeDouble` = 0, `pulseOut` is the XOR of the modulator and the quarter-lag copy. It is high for the first quarter of every base period in which the modulator changed, and low for the rest of that period.
- R9: With `modeDouble` = 1, `pulseOut` is the XOR of the modulator and all three copies. During a burst it is high in the first and third quarters of each period and low in the second and fourth, so it runs at twice the clock rate.
- R10: When no burst is running, `pulseOut` stays low in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0 | input | 1 | Base clock (0° phase) |
| clk90 | input | 1 | Base clock lagging by a quarter period |
| clk180 | input | 1 | Base clock lagging by half a period |
| clk270 | input | 1 | Base clock lagging by three quarters of a period |
| rst | input | 1 | Active-high synchronous reset |
| burstTrigger | input | 1 | Pulse-repetition trigger; a rising edge starts a burst |
| pulseWidth | input | 8 | Burst length in base-clock periods |
| modeDouble | input | 1 | 0: clock-rate burst, 1: double-rate burst |
| pulseOut | output | 1 | Combined pulse output |

## Verification
A wrong count or a wrong modulator state shows up at `pulseOut` within one base period. A high quarter appears where none is expected, or an expected one is missing. This happens in the first period that differs from the expected burst, for example a burst one period too long or too short, or one that fails to restart. A delay register on the wrong phase, or one that samples the wrong value, moves or removes a high quarter inside the same period. For that reason the output is sampled in the middle of every quarter, not once per period.

// File: rtl/upg_pkg.sv
package upg_pkg;
  // Strobes passed from the burst control to the datapath once per base period.
  typedef struct packed {
    logic load;    // start a new burst: modulator goes high
    logic toggle;  // burst running: modulator inverts
  } upg_strobe_t;
endpackage

// File: rtl/upg_ctrl.sv
module upg_ctrl
  import upg_pkg::*;
#(
  parameter int WIDTH_BITS = 8
) (
  input  logic                  clk0,
  input  logic                  rst,
  input  logic                  trigIn,
  input  logic [WIDTH_BITS-1:0] pulseWidth,
  output upg_strobe_t           strobe
);
  localparam logic [WIDTH_BITS-1:0] ONE = WIDTH_BITS'(1);

  logic                  trigSync;
  logic                  trigPrev;
  logic [WIDTH_BITS-1:0] cntQ;
  logic                  start;
  logic                  widthNonZero;

  assign start        = trigSync & ~trigPrev;
  assign widthNonZero = |pulseWidth;

  always_comb begin
    strobe.load   = start & widthNonZero;
    strobe.toggle = ~start & (cntQ != '0);
  end

  always_ff @(posedge clk0) begin
    if (rst) begin
      trigSync <= 1'b0;
      trigPrev <= 1'b0;
      cntQ     <= '0;
    end else begin
      trigSync <= trigIn;
      trigPrev <= trigSync;
      if (start)
        cntQ <= widthNonZero ? pulseWidth - ONE : '0;
      else if (cntQ != '0)
        cntQ <= cntQ - ONE;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk0)
    rst |=> (cntQ == '0 && !trigSync && !trigPrev));

  // R3
  count_step_chk: assert property (@(posedge clk0) disable iff (rst)
    (!start && cntQ != '0) |=> (cntQ == $past(cntQ) - ONE));

  // R5
  reload_chk: assert property (@(posedge clk0) disable iff (rst)
    (start && widthNonZero) |=> (cntQ == $past(pulseWidth) - ONE));

  // R6
  zero_width_chk: assert property (@(posedge clk0) disable iff (rst)
    (start && !widthNonZero) |=> (cntQ == '0 && !strobe.toggle));

  // R4
  held_trigger_chk: assert property (@(posedge clk0) disable iff (rst)
    $past(trigIn) && trigIn && trigSync |=> !strobe.load);
endmodule

// File: rtl/upg_datapath.sv
module upg_datapath
  import upg_pkg::*;
#(
  parameter int NUM_LAG = 3
) (
  input  logic               clk0,
  input  logic [NUM_LAG-1:0] lagClk,
  input  logic               rst,
  input  upg_strobe_t        strobe,
  input  logic               modeDouble,
  output logic               pulseOut
);
  logic               ookQ;
  logic [NUM_LAG-1:0] lagQ;

  // On/off-keyed modulator in the base-clock domain.
  always_ff @(posedge clk0) begin
    if (rst)                ookQ <= 1'b0;
    else if (strobe.load)   ookQ <= 1'b1;
    else if (strobe.toggle) ookQ <= ~ookQ;
    else                    ookQ <= 1'b0;
  end

  // One delay register per lagging phase.
  for (genvar g = 0; g < NUM_LAG; g++) begin : g_lag
    logic lagBit;
    always_ff @(posedge lagClk[g]) begin
      if (rst) lagBit <= 1'b0;
      else     lagBit <= ookQ;
    end
    assign lagQ[g] = lagBit;
  end

  // XOR edge combiner: quarter-lag copy only, or every copy.
  always_comb begin
    if (modeDouble) pulseOut = ookQ ^ (^lagQ);
    else            pulseOut = ookQ ^ lagQ[0];
  end

  // R7
  lag_align_chk: assert property (@(posedge clk0) disable iff (rst)
    lagQ == {NUM_LAG{ookQ}});

  // R10
  edge_quiet_chk: assert property (@(posedge clk0) disable iff (rst)
    !pulseOut);
endmodule

// File: rtl/upg_pulse_gen.sv
module upg_pulse_gen
  import upg_pkg::*;
#(
  parameter int WIDTH_BITS = 8
) (
  input  logic                  clk0,
  input  logic                  clk90,
  input  logic                  clk180,
  input  logic                  clk270,
  input  logic                  rst,
  input  logic                  burstTrigger,
  input  logic [WIDTH_BITS-1:0] pulseWidth,
  input  logic                  modeDouble,
  output logic                  pulseOut
);
  localparam int NUM_LAG = 3;

  upg_strobe_t        strobe;
  logic [NUM_LAG-1:0] lagClk;

  assign lagClk = {clk270, clk180, clk90};

  upg_ctrl #(.WIDTH_BITS(WIDTH_BITS)) u_ctrl (
    .clk0       (clk0),
    .rst        (rst),
    .trigIn     (burstTrigger),
    .pulseWidth (pulseWidth),
    .strobe     (strobe)
  );

  upg_datapath #(.NUM_LAG(NUM_LAG)) u_datapath (
    .clk0       (clk0),
    .lagClk     (lagClk),
    .rst        (rst),
    .strobe     (strobe),
    .modeDouble (modeDouble),
    .pulseOut   (pulseOut)
  );
endmodule

// File: tb/upg_pulse_gen_bench.sv
`timescale 1ns/1ps
module upg_pulse_gen_bench;
  logic clk0 = 1'b0, clk90 = 1'b0, clk180 = 1'b0, clk270 = 1'b0;
  logic rst = 1'b1;
  logic burstTrigger = 1'b0;
  logic [7:0] pulseWidth = 8'd0;
  logic modeDouble = 1'b0;
  logic pulseOut;

  // 250 MHz base clock and three lagging copies
  initial forever #2 clk0 = ~clk0;
  initial begin #1; forever #2 clk90  = ~clk90;  end
  initial begin #2; forever #2 clk180 = ~clk180; end
  initial begin #3; forever #2 clk270 = ~clk270; end

  upg_pulse_gen u_upg_pulse_gen (
    .clk0(clk0), .clk90(clk90), .clk180(clk180), .clk270(clk270),
    .rst(rst), .burstTrigger(burstTrigger), .pulseWidth(pulseWidth),
    .modeDouble(modeDouble), .pulseOut(pulseOut)
  );

  int checks = 0;
  int errors = 0;
  bit monOn = 1'b0;
  bit expQ[$];
  string reqTag = "R1";
  bit tLast = 1'b0;
  bit mO = 1'b0;
  int mC = 0;
  bit prevO = 1'b0;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pulseOut=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: drives one base period and queues the modulator level expected
  // two periods later (trigger register plus modulator register).
  task automatic cyc(input bit trig);
    bit nO;
    int nC;
    @(posedge clk0);
    #0.25;
    burstTrigger = trig;
    if (trig && !tLast) begin
      nO = (pulseWidth != 0);
      nC = (pulseWidth != 0) ? int'(pulseWidth) - 1 : 0;
    end else if (mC != 0) begin
      nO = !mO;
      nC = mC - 1;
    end else begin
      nO = 1'b0;
      nC = 0;
    end
    tLast = trig;
    mO = nO;
    mC = nC;
    expQ.push_back(nO);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0);
  endtask

  // Monitor: compares each quarter of every base period (R7 R8 R9 R10).
  initial forever begin
    @(posedge clk0);
    if (monOn) begin
      bit o;
      bit d;
      if (expQ.size() == 0) begin
        o = 1'b0;
        checks++; errors++;
        $display("FAIL %s: scoreboard empty, actual n/a expected entry", reqTag);
      end else begin
        o = expQ.pop_front();
      end
      d = o ^ prevO;
      #0.5 check(reqTag, pulseOut, d);
      #1   check(reqTag, pulseOut, 1'b0);
      #1   check(reqTag, pulseOut, modeDouble ? d : 1'b0);
      #1   check(reqTag, pulseOut, 1'b0);
      prevO = o;
    end
  end

  initial begin
    #20000;
    checks++; errors++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: output low throughout reset
    for (int i = 0; i < 4; i++) begin
      @(posedge clk0);
      #0.5 check("R1", pulseOut, 1'b0);
      #2   check("R1", pulseOut, 1'b0);
    end
    @(posedge clk0);
    #0.25 rst = 1'b0;
    expQ.push_back(1'b0);
    expQ.push_back(1'b0);
    monOn = 1'b1;

    // R1 R10: quiet after reset
    reqTag = "R1 R10";
    idle(4);

    // R2 R3 R8: clock-rate burst of five periods
    reqTag = "R2 R3 R8";
    pulseWidth = 8'd5; modeDouble = 1'b0;
    cyc(1'b1); cyc(1'b1); idle(10);

    // R9 R7: double-rate burst of six periods
    reqTag = "R9 R7";
    pulseWidth = 8'd6; modeDouble = 1'b1;
    cyc(1'b1); idle(11);

    // R4: trigger held high for a long time starts only one burst
    reqTag = "R4";
    pulseWidth = 8'd3;
    for (int i = 0; i < 12; i++) cyc(1'b1);
    idle(4);

    // R5: retrigger in the middle of a burst
    reqTag = "R5";
    pulseWidth = 8'd8;
    cyc(1'b1); idle(3); cyc(1'b1); idle(14);

    // R6: zero width produces nothing
    reqTag = "R6";
    pulseWidth = 8'd0; modeDouble = 1'b0;
    cyc(1'b1); idle(6);

    // R3: single-period burst (boundary)
    reqTag = "R3 R8";
    pulseWidth = 8'd1;
    cyc(1'b1); idle(6);

    // R3: maximum width
    reqTag = "R3 R9";
    pulseWidth = 8'd255; modeDouble = 1'b1;
    cyc(1'b1); idle(262);

    // R10: idle in both modes
    reqTag = "R10";
    idle(4);
    modeDouble = 1'b0;
    idle(4);

    @(posedge clk0);
    #3.75 monOn = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule